// File: doc/BRIEF.md
# Tiled Loop-Nest Address Generator

This block sequences a one-dimensional convolution, out[p] += w[r] * in[r + p], that a mapping step has split into several tiling levels. Each level owns one loop over the filter dimension r and one over the output dimension p, and each loop has its own bound. A per-level order bit decides which of the two loops runs faster inside that level. For every step the block presents a weight address, an input address and an output address together with a valid strobe. A downstream buffer and multiply-accumulate stage consume these.

One level is marked as the spatial level. The block does not build one copy of the sequencer per lane. Instead it visits the spatial level's points fastest and reports the lane they belong to as a flattened lane number. The block also raises a first-touch flag on the first visit to each output address, so an accumulator can start from zero instead of reading a stale partial sum. Software loads the bounds and order bits as part of a start request while the block is idle. A stall input lets the consumer hold the current step.

Top module: `tlag_top`

## Requirements
- R1: After reset, busy, done, o_vld and cfg_err are all low.
- R2: A start seen while idle with every bound non-zero captures the configuration and raises busy on the next cycle. The first step appears on o_vld one cycle after that, provided stall is low.
- R3: Each level i holds digits r_i < RB_i and p_i < PB_i. The global indices are formed in mixed radix with level NLVL-1 as the most significant digit: r = (..(r3·RB2 + r2)·RB1 + r1)·RB0 + r0, and p likewise. The outputs are o_w_addr = r, o_o_addr = p and o_i_addr = r + p.
- R4: The spatial level (level SP_LVL) advances fastest, then the remaining levels in ascending order. Inside a level, order bit 0 runs p fastest with r fixed, so the weight address holds across consecutive steps. Order bit 1 runs r fastest. The bounds of level i sit at bits [i·BW +: BW] of cfg_r_bnd and cfg_p_bnd, and its order bit is cfg_perm[i].
- R5: While stall is high, a pending step keeps o_vld and all address, lane and first-touch outputs unchanged, and no counter advances. A step counts as accepted on a rising edge where o_vld is high and stall is low.
- R6: done is high for exactly one cycle, in the cycle right after the step with r = R−1 and p = P−1 is accepted. busy is low in that same cycle.
- R7: A start seen while idle with any bound equal to 0 sets cfg_err and does not start. cfg_err is cleared by the next accepted start.
- R8: start, bound and order inputs have no effect while busy. The running sequence and cfg_err stay unchanged.
- R9: o_lane equals r_s·PB_s + p_s, where s is the spatial level, and it is aligned with the addresses.
- R10: o_first is high exactly on the first accepted step that carries each output address.
- R11: A run emits exactly R·P steps, where R and P are the products of the bounds over all levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to load the configuration and run |
| stall | input | 1 | Holds the current step and freezes sequencing |
| cfg_r_bnd | input | NLVL*BW | Per-level filter-loop bounds |
| cfg_p_bnd | input | NLVL*BW | Per-level output-loop bounds |
| cfg_perm | input | NLVL | Per-level loop order bit |
| busy | output | 1 | A run is in progress or a step is pending |
| done | output | 1 | One-cycle pulse after the final step is accepted |
| cfg_err | output | 1 | Last start was refused because a bound was zero |
| o_vld | output | 1 | Step outputs are valid |
| o_w_addr | output | WA_W | Weight buffer address |
| o_i_addr | output | IA_W | Input buffer address |
| o_o_addr | output | OA_W | Output buffer address |
| o_lane | output | LANE_W | Flattened spatial lane number |
| o_first | output | 1 | First visit to this output address |

## Verification
The properties assume that the bound products per dimension fit the weight and output buffer depths, so no global index wraps. They also assume reset is applied before the first start. The stimulus picks bounds whose products stay within the default depths of 64 entries. It holds reset for several cycles at the start. It drives stall in fixed periodic patterns, including during the final step, and raises start with a zero bound only while a run is active or during the dedicated refusal test.

// File: rtl/tlag_pkg.sv
package tlag_pkg;

  // Position k in the advance chain -> tiling level number.
  // The spatial level is swept first; the rest follow in ascending order.
  function automatic int iter_level(input int k, input int sp);
    if (k == 0) return sp;
    if (k <= sp) return k - 1;
    return k;
  endfunction

  typedef enum logic {ORD_P_FAST = 1'b0, ORD_R_FAST = 1'b1} loop_order_e;

endpackage

// File: rtl/tlag_level.sv
// One tiling level: a pair of digit counters with a selectable inner loop.
module tlag_level #(
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  input  logic [BW-1:0] rb,
  input  logic [BW-1:0] pb,
  input  logic          perm,
  output logic [BW-1:0] r_idx,
  output logic [BW-1:0] p_idx,
  output logic          at_end
);
  import tlag_pkg::*;

  logic r_top, p_top;

  assign r_top  = (r_idx == rb - BW'(1));
  assign p_top  = (p_idx == pb - BW'(1));
  assign at_end = r_top & p_top;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      r_idx <= '0;
      p_idx <= '0;
    end else if (adv) begin
      if (loop_order_e'(perm) == ORD_P_FAST) begin
        if (p_top) begin
          p_idx <= '0;
          r_idx <= r_top ? '0 : r_idx + BW'(1);
        end else begin
          p_idx <= p_idx + BW'(1);
        end
      end else begin
        if (r_top) begin
          r_idx <= '0;
          p_idx <= p_top ? '0 : p_idx + BW'(1);
        end else begin
          r_idx <= r_idx + BW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/tlag_compose.sv
// Mixed-radix composition of per-level digits into one global index.
module tlag_compose #(
  parameter int NLVL = 4,
  parameter int BW   = 4,
  parameter int OW   = 6
) (
  input  logic [NLVL*BW-1:0] idx,
  input  logic [NLVL*BW-1:0] bnd,
  output logic [OW-1:0]      val
);
  localparam int PW = OW + BW;

  logic [OW-1:0] acc [NLVL];

  assign acc[NLVL-1] = OW'(idx[(NLVL-1)*BW +: BW]);

  for (genvar i = NLVL - 2; i >= 0; i--) begin : g_horner
    logic [PW-1:0] prod;
    assign prod   = PW'(acc[i+1]) * PW'(bnd[i*BW +: BW]);
    assign acc[i] = OW'(prod) + OW'(idx[i*BW +: BW]);
  end

  assign val = acc[0];

endmodule

// File: rtl/tlag_top.sv
module tlag_top #(
  parameter int NLVL   = 4,
  parameter int BW     = 4,
  parameter int SP_LVL = 1,
  parameter int R_ENT  = 64,
  parameter int P_ENT  = 64,
  localparam int WA_W   = $clog2(R_ENT),
  localparam int OA_W   = $clog2(P_ENT),
  localparam int IA_W   = $clog2(R_ENT + P_ENT - 1),
  localparam int LANE_W = 2 * BW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               stall,
  input  logic [NLVL*BW-1:0] cfg_r_bnd,
  input  logic [NLVL*BW-1:0] cfg_p_bnd,
  input  logic [NLVL-1:0]    cfg_perm,
  output logic               busy,
  output logic               done,
  output logic               cfg_err,
  output logic               o_vld,
  output logic [WA_W-1:0]    o_w_addr,
  output logic [IA_W-1:0]    o_i_addr,
  output logic [OA_W-1:0]    o_o_addr,
  output logic [LANE_W-1:0]  o_lane,
  output logic               o_first
);
  import tlag_pkg::*;

  // Latched configuration
  logic [NLVL*BW-1:0] rb_q, pb_q;
  logic [NLVL-1:0]    perm_q;
  logic               run_q;
  logic               last_q;

  logic cfg_zero;
  logic accept, reject, step;

  always_comb begin
    cfg_zero = 1'b0;
    for (int i = 0; i < NLVL; i++) begin
      if (cfg_r_bnd[i*BW +: BW] == '0 || cfg_p_bnd[i*BW +: BW] == '0)
        cfg_zero = 1'b1;
    end
  end

  assign busy   = run_q | o_vld;
  assign accept = start & ~busy & ~cfg_zero;
  assign reject = start & ~busy &  cfg_zero;
  assign step   = run_q & ~stall;

  // Level counters, chained in sweep order
  logic [NLVL*BW-1:0] r_idx, p_idx;
  logic [NLVL-1:0]    at_end;
  logic [NLVL:0]      carry;

  assign carry[0] = step;

  for (genvar k = 0; k < NLVL; k++) begin : g_lvl
    localparam int L = iter_level(k, SP_LVL);
    tlag_level #(.BW(BW)) u_lvl (
      .clk   (clk),
      .rst   (rst),
      .clr   (accept),
      .adv   (carry[k]),
      .rb    (rb_q[L*BW +: BW]),
      .pb    (pb_q[L*BW +: BW]),
      .perm  (perm_q[L]),
      .r_idx (r_idx[L*BW +: BW]),
      .p_idx (p_idx[L*BW +: BW]),
      .at_end(at_end[L])
    );
    assign carry[k+1] = carry[k] & at_end[L];
  end

  logic last_pt;
  assign last_pt = &at_end;

  // Global index composition
  logic [WA_W-1:0] r_glob;
  logic [OA_W-1:0] p_glob;

  tlag_compose #(.NLVL(NLVL), .BW(BW), .OW(WA_W)) u_rcomp (
    .idx(r_idx), .bnd(rb_q), .val(r_glob)
  );
  tlag_compose #(.NLVL(NLVL), .BW(BW), .OW(OA_W)) u_pcomp (
    .idx(p_idx), .bnd(pb_q), .val(p_glob)
  );

  logic [LANE_W-1:0] lane_c;
  assign lane_c = LANE_W'(r_idx[SP_LVL*BW +: BW]) * LANE_W'(pb_q[SP_LVL*BW +: BW])
                + LANE_W'(p_idx[SP_LVL*BW +: BW]);

  // Control and registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      rb_q     <= '0;
      pb_q     <= '0;
      perm_q   <= '0;
      run_q    <= 1'b0;
      last_q   <= 1'b0;
      done     <= 1'b0;
      cfg_err  <= 1'b0;
      o_vld    <= 1'b0;
      o_w_addr <= '0;
      o_i_addr <= '0;
      o_o_addr <= '0;
      o_lane   <= '0;
      o_first  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        rb_q    <= cfg_r_bnd;
        pb_q    <= cfg_p_bnd;
        perm_q  <= cfg_perm;
        run_q   <= 1'b1;
        cfg_err <= 1'b0;
      end
      if (reject) cfg_err <= 1'b1;
      if (!stall) begin
        o_vld <= run_q;
        if (o_vld && last_q) done <= 1'b1;
        if (run_q) begin
          o_w_addr <= r_glob;
          o_o_addr <= p_glob;
          o_i_addr <= IA_W'(r_glob) + IA_W'(p_glob);
          o_lane   <= lane_c;
          o_first  <= (r_glob == '0);
          last_q   <= last_pt;
          if (last_pt) run_q <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/tlag_chk.sv
module tlag_chk #(
  parameter int WA_W   = 6,
  parameter int IA_W   = 7,
  parameter int OA_W   = 6,
  parameter int LANE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              stall,
  input logic              busy,
  input logic              done,
  input logic              cfg_err,
  input logic              o_vld,
  input logic [WA_W-1:0]   o_w_addr,
  input logic [IA_W-1:0]   o_i_addr,
  input logic [OA_W-1:0]   o_o_addr,
  input logic [LANE_W-1:0] o_lane,
  input logic              o_first
);

  a_r5_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (o_vld && stall) |=> (o_vld && $stable(o_w_addr) && $stable(o_i_addr) &&
                          $stable(o_o_addr) && $stable(o_lane) && $stable(o_first)));

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_done_after_step: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(o_vld) && !busy));

  a_r7_err_idle: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !busy);

  a_r2_first_step: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && !stall) |=> o_vld);

  a_r10_first_at_origin: assert property (@(posedge clk) disable iff (rst)
    $rose(o_vld) |-> (o_first && o_o_addr == '0 && o_w_addr == '0));

endmodule

bind tlag_top tlag_chk #(
  .WA_W(WA_W), .IA_W(IA_W), .OA_W(OA_W), .LANE_W(LANE_W)
) u_chk (
  .clk(clk), .rst(rst), .stall(stall), .busy(busy), .done(done),
  .cfg_err(cfg_err), .o_vld(o_vld), .o_w_addr(o_w_addr), .o_i_addr(o_i_addr),
  .o_o_addr(o_o_addr), .o_lane(o_lane), .o_first(o_first)
);

// File: tb/tlag_top_tb.sv
module tlag_top_tb;
  localparam int NLVL = 4;
  localparam int BW   = 4;
  localparam int SP   = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic stall = 1'b0;
  logic [NLVL*BW-1:0] rb_in = '0;
  logic [NLVL*BW-1:0] pb_in = '0;
  logic [NLVL-1:0]    perm_in = '0;

  logic       busy, done, cfg_err, o_vld, o_first;
  logic [5:0] o_w_addr, o_o_addr;
  logic [6:0] o_i_addr;
  logic [7:0] o_lane;

  tlag_top u_dut (
    .clk(clk), .rst(rst), .start(start), .stall(stall),
    .cfg_r_bnd(rb_in), .cfg_p_bnd(pb_in), .cfg_perm(perm_in),
    .busy(busy), .done(done), .cfg_err(cfg_err), .o_vld(o_vld),
    .o_w_addr(o_w_addr), .o_i_addr(o_i_addr), .o_o_addr(o_o_addr),
    .o_lane(o_lane), .o_first(o_first)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  int exp_r  [4096];
  int exp_p  [4096];
  int exp_ln [4096];
  bit exp_f  [4096];

  task automatic check(input bit ok, input string req, input string msg);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // Expected step list from the requirement text (R3 R4 R9 R10 R11)
  task automatic build(input logic [NLVL*BW-1:0] rb, input logic [NLVL*BW-1:0] pb,
                       input logic [NLVL-1:0] perm, output int n);
    bit seen [64];
    n = 1;
    for (int l = 0; l < NLVL; l++) n = n * int'(rb[l*BW +: BW]) * int'(pb[l*BW +: BW]);
    for (int i = 0; i < 64; i++) seen[i] = 1'b0;
    for (int t = 0; t < n; t++) begin
      int rem, r, p;
      int rd [NLVL];
      int pd [NLVL];
      rem = t;
      for (int k = 0; k < NLVL; k++) begin
        int lv, rbv, pbv;
        lv  = (k == 0) ? SP : ((k <= SP) ? k - 1 : k);
        rbv = int'(rb[lv*BW +: BW]);
        pbv = int'(pb[lv*BW +: BW]);
        if (!perm[lv]) begin
          pd[lv] = rem % pbv; rem = rem / pbv;
          rd[lv] = rem % rbv; rem = rem / rbv;
        end else begin
          rd[lv] = rem % rbv; rem = rem / rbv;
          pd[lv] = rem % pbv; rem = rem / pbv;
        end
      end
      r = 0; p = 0;
      for (int l = NLVL - 1; l >= 0; l--) begin
        r = r * int'(rb[l*BW +: BW]) + rd[l];
        p = p * int'(pb[l*BW +: BW]) + pd[l];
      end
      exp_r[t]  = r;
      exp_p[t]  = p;
      exp_ln[t] = rd[SP] * int'(pb[SP*BW +: BW]) + pd[SP];
      exp_f[t]  = !seen[p];
      seen[p]   = 1'b1;
    end
  endtask

  task automatic run_job(input logic [NLVL*BW-1:0] rb, input logic [NLVL*BW-1:0] pb,
                         input logic [NLVL-1:0] perm, input int stall_mod,
                         input bit poke, input string name);
    int n, got, cyc;
    bit prev_hold, early_done;
    logic [5:0] s_w, s_o;
    logic [6:0] s_i;
    logic [7:0] s_l;
    logic       s_f;
    build(rb, pb, perm, n);
    @(negedge clk);
    rb_in = rb; pb_in = pb; perm_in = perm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !o_vld, "R2", $sformatf("%s start: busy=%0b o_vld=%0b exp 1/0", name, busy, o_vld));
    check(!cfg_err, "R7", $sformatf("%s cfg_err after start=%0b exp 0", name, cfg_err));
    got = 0; cyc = 0; prev_hold = 1'b0; early_done = 1'b0;
    s_w = '0; s_o = '0; s_i = '0; s_l = '0; s_f = 1'b0;
    while (got < n && cyc < 20000) begin
      bit s;
      s = (stall_mod > 0) && (cyc % stall_mod == 2);
      stall = s;
      if (poke && cyc == 3) begin
        start = 1'b1; rb_in = {NLVL{4'd1}}; pb_in = '0; perm_in = ~perm;
      end else if (poke && cyc == 4) begin
        start = 1'b0;
      end
      if (done) early_done = 1'b1;
      if (prev_hold)
        check(o_vld && o_w_addr == s_w && o_o_addr == s_o && o_i_addr == s_i &&
              o_lane == s_l && o_first == s_f, "R5",
              $sformatf("%s stall hold: w=%0d o=%0d exp w=%0d o=%0d", name, o_w_addr, o_o_addr, s_w, s_o));
      if (o_vld && !s) begin
        check(int'(o_w_addr) == exp_r[got] && int'(o_o_addr) == exp_p[got], "R4",
              $sformatf("%s step %0d: w=%0d o=%0d exp w=%0d o=%0d", name, got,
                        o_w_addr, o_o_addr, exp_r[got], exp_p[got]));
        check(int'(o_i_addr) == exp_r[got] + exp_p[got], "R3",
              $sformatf("%s step %0d: i=%0d exp %0d", name, got, o_i_addr, exp_r[got] + exp_p[got]));
        check(int'(o_lane) == exp_ln[got], "R9",
              $sformatf("%s step %0d: lane=%0d exp %0d", name, got, o_lane, exp_ln[got]));
        check(o_first == exp_f[got], "R10",
              $sformatf("%s step %0d: first=%0b exp %0b", name, got, o_first, exp_f[got]));
        got++;
      end
      prev_hold = o_vld && s;
      s_w = o_w_addr; s_o = o_o_addr; s_i = o_i_addr; s_l = o_lane; s_f = o_first;
      @(negedge clk);
      cyc++;
    end
    check(got == n, "R11", $sformatf("%s steps=%0d exp %0d", name, got, n));
    check(!early_done, "R6", $sformatf("%s early done=%0b exp 0", name, early_done));
    check(done && !busy && !o_vld, "R6",
          $sformatf("%s end: done=%0b busy=%0b vld=%0b exp 1/0/0", name, done, busy, o_vld));
    stall = 1'b0;
    @(negedge clk);
    check(!done && !o_vld, "R11", $sformatf("%s after: done=%0b vld=%0b exp 0/0", name, done, o_vld));
    if (poke) check(!cfg_err, "R8", $sformatf("%s cfg_err=%0b exp 0", name, cfg_err));
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !o_vld && !cfg_err, "R1",
          $sformatf("reset: busy=%0b done=%0b vld=%0b err=%0b exp 0", busy, done, o_vld, cfg_err));
  endtask

  task automatic t_zero_bound();
    @(negedge clk);
    rb_in = {4'd2, 4'd1, 4'd0, 4'd2}; pb_in = {4'd1, 4'd2, 4'd2, 4'd3}; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(cfg_err && !busy, "R7", $sformatf("zero bound: err=%0b busy=%0b exp 1/0", cfg_err, busy));
    repeat (3) @(negedge clk);
    check(cfg_err && !busy && !o_vld, "R7",
          $sformatf("zero bound later: err=%0b busy=%0b vld=%0b exp 1/0/0", cfg_err, busy, o_vld));
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "WDOG", "watchdog expired: got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    // level order in vectors: {L3, L2, L1, L0}
    run_job({4'd2, 4'd1, 4'd2, 4'd2}, {4'd1, 4'd2, 4'd2, 4'd3}, 4'b0000, 0, 1'b0, "p_fast");
    run_job({4'd2, 4'd1, 4'd2, 4'd2}, {4'd1, 4'd2, 4'd2, 4'd3}, 4'b1010, 3, 1'b0, "mixed_a");
    t_zero_bound();
    run_job({4'd1, 4'd2, 4'd1, 4'd3}, {4'd2, 4'd1, 4'd3, 4'd2}, 4'b0101, 5, 1'b1, "mixed_b");
    run_job({4'd1, 4'd1, 4'd1, 4'd1}, {4'd1, 4'd1, 4'd1, 4'd1}, 4'b0000, 0, 1'b0, "unit");
    run_job({4'd1, 4'd2, 4'd3, 4'd2}, {4'd2, 4'd2, 4'd2, 4'd2}, 4'b1111, 2, 1'b0, "r_fast");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule